// File: doc/BRIEF.md
# Chip Reset Sequencer with Cause Capture

This block controls the reset of a whole chip. Several sources can ask for a reset: an external reset pin, a clock monitor that reports a lost clock or reference, a watchdog or debug request, and software. Software uses a two-bit control register. One bit starts a full system reset. The other bit sends a reset pulse to the outside world only, and leaves the sequencer running.

Once a system reset starts, the block holds its active-low reset output low. It captures the wake-up configuration pin straight away. It captures the PLL configuration pins at the same moment, but only when the reset-config select pin is high. It then waits for the PLL to report lock and counts a fixed number of cycles. At the end of that count it captures the wake-up pin again, and captures the boot configuration pins if select is high. Four more cycles later it releases the reset. At that release it writes the cause of the reset into a one-hot status register, which a bus can read.

A new request that arrives while a sequence is running starts the sequence again from the beginning.

Top module: `rstseq_top`

## Requirements
- R1: The synchronous active-high `rst` holds `rst_out_n` and `ext_rst_n` low and clears `cause` and `ctl_rd`. After `rst` falls, a full sequence runs, and on release `cause` reads 5'b10000 (power-on, bit 4).
- R2: A loss-of-clock request exists only while `clk_fail` and `loc_rst_en` are both high. `clk_fail` with the enable low changes neither `rst_out_n` nor `cause`.
- R3: On the clock edge that enters the sequence, `wake_cfg` takes `wake_pin`. On that same edge `pll_cfg` takes `pll_cfg_pin` only if `cfg_sel` is high; otherwise `pll_cfg` keeps its value.
- R4: `rst_out_n` stays low while `pll_locked` is low. From the edge that first sees lock, release follows after exactly LOCK_WAIT+4 cycles. With lock already high, `rst_out_n` is low for LOCK_WAIT+6 cycles (22 by default).
- R5: When the post-lock count ends, `wake_cfg` is sampled again. `boot_cfg` takes `boot_cfg_pin` only if `cfg_sel` is high. Pin changes during the last four cycles before release have no effect, and the configuration outputs never change while out of reset.
- R6: `cause` changes only on the edge that releases `rst_out_n`. It then holds exactly one bit, the winning cause: bit 0 external pin, bit 1 loss-of-clock, bit 2 watchdog/debug, bit 3 software system reset, bit 4 power-on.
- R7: Requests in the same cycle are ranked external pin first, then loss-of-clock, then watchdog/debug, then software system reset.
- R8: Writing `ctl_wdata[0]`=1 with `ctl_wr` starts a full sequence. `ctl_rd[0]` reads 1 until the sequence is entered, then clears by itself.
- R9: Writing `ctl_wdata[1]`=1 drives `ext_rst_n` low for EXT_PULSE cycles (8 by default). It leaves `rst_out_n` high and `cause` unchanged, and `ctl_rd[1]` clears when the pulse starts. `ext_rst_n` is also low whenever `rst_out_n` is low.
- R10: A request during a running sequence restarts it from the assert step. Release follows LOCK_WAIT+6 cycles after the new request, and the cause reported is the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pll_locked | input | 1 | PLL lock flag |
| clk_fail | input | 1 | Clock or reference failure detected |
| loc_rst_en | input | 1 | Enable for loss-of-clock reset |
| ext_rst_req | input | 1 | External reset pin request, active high |
| wdog_req | input | 1 | Watchdog or debug reset request |
| cfg_sel | input | 1 | Reset-config select pin |
| wake_pin | input | 1 | Wake-up configuration pin |
| pll_cfg_pin | input | PLL_W | PLL configuration pins |
| boot_cfg_pin | input | BOOT_W | Boot configuration pins |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Write data: bit 0 system reset, bit 1 external reset |
| ctl_rd | output | 2 | Control register readback |
| rst_out_n | output | 1 | Active-low chip reset output |
| ext_rst_n | output | 1 | Active-low external reset output |
| wake_cfg | output | 1 | Captured wake-up configuration |
| pll_cfg | output | PLL_W | Captured PLL configuration |
| boot_cfg | output | BOOT_W | Captured boot configuration |
| cause | output | 5 | One-hot reset cause status |

## Verification
Several rules are checked by assertions on every cycle:
- the cause register changes only on release and is never more than one-hot;
- a request always pulls both reset outputs low on the next cycle;
- with no request pending, the chip does not fall into reset;
- the captured configuration never moves while out of reset;
- the software system bit clears one cycle after it is set.

Other behaviours need the bench's scenarios:
- the exact release timing relative to PLL lock;
- which pin values were captured at the two sampling points;
- the ranking of simultaneous requests;
- the restart length;
- the width of the software external pulse.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int CAUSE_W     = 5;
    localparam int TAIL_CYCLES = 4;

    localparam int C_EXT   = 0;
    localparam int C_LOC   = 1;
    localparam int C_WDOG  = 2;
    localparam int C_SWSYS = 3;
    localparam int C_POR   = 4;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_ASSERT,
        ST_WAIT_LOCK,
        ST_COUNT,
        ST_TAIL
    } seq_state_e;

    // Least significant field has the highest priority.
    typedef struct packed {
        logic swsys;
        logic wdog;
        logic loc;
        logic ext;
    } req_t;

    typedef logic [CAUSE_W-1:0] cause_t;

    function automatic cause_t cause_bit(input int idx);
        cause_t c;
        c = '0;
        c[idx] = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/rstseq_arbiter.sv
module rstseq_arbiter
    import rstseq_pkg::*;
(
    input  req_t   req,
    output logic   req_any,
    output cause_t win_cause
);
    localparam int NREQ = $bits(req_t);

    logic [NREQ-1:0] req_vec;
    logic            found;

    assign req_vec = req;
    assign req_any = |req_vec;

    always_comb begin
        win_cause = '0;
        found     = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            if (req_vec[i] && !found) begin
                win_cause[i] = 1'b1;
                found        = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int LOCK_WAIT = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_any,
    input  cause_t win_cause,
    input  logic   pll_locked,
    output logic   seq_active,
    output logic   final_smp,
    output cause_t cause_q
);
    localparam int SPAN      = (LOCK_WAIT > TAIL_CYCLES) ? LOCK_WAIT : TAIL_CYCLES;
    localparam int CNT_W     = $clog2(SPAN);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(LOCK_WAIT - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_CYCLES - 1);

    seq_state_e        state;
    logic [CNT_W-1:0]  cnt;
    cause_t            pend;

    assign seq_active = (state != ST_RUN);
    assign final_smp  = !req_any && (state == ST_COUNT) && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_ASSERT;
            cnt     <= '0;
            pend    <= cause_bit(C_POR);
            cause_q <= '0;
        end else if (req_any) begin
            state <= ST_ASSERT;
            cnt   <= '0;
            pend  <= win_cause;
        end else begin
            case (state)
                ST_ASSERT: state <= ST_WAIT_LOCK;
                ST_WAIT_LOCK: begin
                    if (pll_locked) begin
                        state <= ST_COUNT;
                        cnt   <= '0;
                    end
                end
                ST_COUNT: begin
                    if (cnt == CNT_LAST) begin
                        state <= ST_TAIL;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (cnt == TAIL_LAST) begin
                        state   <= ST_RUN;
                        cause_q <= pend;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/rstseq_cfg_capture.sv
module rstseq_cfg_capture #(
    parameter int PLL_W  = 2,
    parameter int BOOT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              entry,
    input  logic              final_smp,
    input  logic              cfg_sel,
    input  logic              wake_pin,
    input  logic [PLL_W-1:0]  pll_cfg_pin,
    input  logic [BOOT_W-1:0] boot_cfg_pin,
    output logic              wake_cfg,
    output logic [PLL_W-1:0]  pll_cfg,
    output logic [BOOT_W-1:0] boot_cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wake_cfg <= 1'b0;
            pll_cfg  <= '0;
            boot_cfg <= '0;
        end else if (entry) begin
            wake_cfg <= wake_pin;
            if (cfg_sel) pll_cfg <= pll_cfg_pin;
        end else if (final_smp) begin
            wake_cfg <= wake_pin;
            if (cfg_sel) boot_cfg <= boot_cfg_pin;
        end
    end
endmodule

// File: rtl/rstseq_swctl.sv
module rstseq_swctl #(
    parameter int EXT_PULSE = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic [1:0] ctl_wdata,
    input  logic       seq_entry,
    output logic       swsys_q,
    output logic       swext_q,
    output logic       pulse_active
);
    localparam int PW = $clog2(EXT_PULSE + 1);
    localparam logic [PW-1:0] PULSE_LEN = PW'(EXT_PULSE);

    logic [PW-1:0] pcnt;
    logic          pulse_start;

    assign pulse_start  = swext_q && (pcnt == '0);
    assign pulse_active = (pcnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            swsys_q <= 1'b0;
            swext_q <= 1'b0;
            pcnt    <= '0;
        end else begin
            if (ctl_wr && ctl_wdata[0])  swsys_q <= 1'b1;
            else if (seq_entry)          swsys_q <= 1'b0;

            if (ctl_wr && ctl_wdata[1])  swext_q <= 1'b1;
            else if (pulse_start)        swext_q <= 1'b0;

            if (pulse_start)             pcnt <= PULSE_LEN;
            else if (pcnt != '0)         pcnt <= pcnt - 1'b1;
        end
    end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int LOCK_WAIT = 16,
    parameter int EXT_PULSE = 8,
    parameter int PLL_W     = 2,
    parameter int BOOT_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pll_locked,
    input  logic              clk_fail,
    input  logic              loc_rst_en,
    input  logic              ext_rst_req,
    input  logic              wdog_req,
    input  logic              cfg_sel,
    input  logic              wake_pin,
    input  logic [PLL_W-1:0]  pll_cfg_pin,
    input  logic [BOOT_W-1:0] boot_cfg_pin,
    input  logic              ctl_wr,
    input  logic [1:0]        ctl_wdata,
    output logic [1:0]        ctl_rd,
    output logic              rst_out_n,
    output logic              ext_rst_n,
    output logic              wake_cfg,
    output logic [PLL_W-1:0]  pll_cfg,
    output logic [BOOT_W-1:0] boot_cfg,
    output logic [4:0]        cause
);
    req_t   req;
    logic   req_any;
    cause_t win_cause;
    logic   seq_active;
    logic   final_smp;
    logic   swsys_q;
    logic   swext_q;
    logic   pulse_active;
    cause_t cause_q;

    always_comb begin
        req.ext   = ext_rst_req;
        req.loc   = clk_fail & loc_rst_en;
        req.wdog  = wdog_req;
        req.swsys = swsys_q;
    end

    rstseq_arbiter u_arb (
        .req       (req),
        .req_any   (req_any),
        .win_cause (win_cause)
    );

    rstseq_fsm #(.LOCK_WAIT(LOCK_WAIT)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_any    (req_any),
        .win_cause  (win_cause),
        .pll_locked (pll_locked),
        .seq_active (seq_active),
        .final_smp  (final_smp),
        .cause_q    (cause_q)
    );

    rstseq_cfg_capture #(.PLL_W(PLL_W), .BOOT_W(BOOT_W)) u_cfg (
        .clk          (clk),
        .rst          (rst),
        .entry        (req_any),
        .final_smp    (final_smp),
        .cfg_sel      (cfg_sel),
        .wake_pin     (wake_pin),
        .pll_cfg_pin  (pll_cfg_pin),
        .boot_cfg_pin (boot_cfg_pin),
        .wake_cfg     (wake_cfg),
        .pll_cfg      (pll_cfg),
        .boot_cfg     (boot_cfg)
    );

    rstseq_swctl #(.EXT_PULSE(EXT_PULSE)) u_sw (
        .clk          (clk),
        .rst          (rst),
        .ctl_wr       (ctl_wr),
        .ctl_wdata    (ctl_wdata),
        .seq_entry    (req_any),
        .swsys_q      (swsys_q),
        .swext_q      (swext_q),
        .pulse_active (pulse_active)
    );

    assign rst_out_n = !seq_active;
    assign ext_rst_n = !(seq_active || pulse_active);
    assign ctl_rd    = {swext_q, swsys_q};
    assign cause     = cause_q;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int PLL_W  = 2,
    parameter int BOOT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_fail,
    input logic              loc_rst_en,
    input logic              ext_rst_req,
    input logic              wdog_req,
    input logic              ctl_wr,
    input logic [1:0]        ctl_rd,
    input logic              rst_out_n,
    input logic              ext_rst_n,
    input logic              wake_cfg,
    input logic [PLL_W-1:0]  pll_cfg,
    input logic [BOOT_W-1:0] boot_cfg,
    input logic [4:0]        cause
);
    assert_no_spurious_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (rst_out_n && !ext_rst_req && !wdog_req && !ctl_rd[0] && !(clk_fail && loc_rst_en))
        |=> rst_out_n);

    assert_request_enters_R10: assert property (@(posedge clk) disable iff (rst)
        (ext_rst_req || wdog_req || (clk_fail && loc_rst_en)) |=> (!rst_out_n && !ext_rst_n));

    assert_cause_on_release_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(cause) |-> $rose(rst_out_n));

    assert_cause_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cause));

    assert_ext_covers_sys_R9: assert property (@(posedge clk) disable iff (rst)
        !rst_out_n |-> !ext_rst_n);

    assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (rst_out_n && $past(rst_out_n)) |-> ($stable(pll_cfg) && $stable(boot_cfg) && $stable(wake_cfg)));

    assert_swsys_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd[0] && !ctl_wr) |=> !ctl_rd[0]);
endmodule

bind rstseq_top rstseq_chk #(.PLL_W(PLL_W), .BOOT_W(BOOT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clk_fail    (clk_fail),
    .loc_rst_en  (loc_rst_en),
    .ext_rst_req (ext_rst_req),
    .wdog_req    (wdog_req),
    .ctl_wr      (ctl_wr),
    .ctl_rd      (ctl_rd),
    .rst_out_n   (rst_out_n),
    .ext_rst_n   (ext_rst_n),
    .wake_cfg    (wake_cfg),
    .pll_cfg     (pll_cfg),
    .boot_cfg    (boot_cfg),
    .cause       (cause)
);

// File: tb/rstseq_top_bench.sv
module rstseq_top_bench;

    localparam int SEQ_LEN  = 22;
    localparam int POST_LCK = 20;
    localparam int PULSE    = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pll_locked = 1'b1;
    logic       clk_fail = 1'b0;
    logic       loc_rst_en = 1'b0;
    logic       ext_rst_req = 1'b0;
    logic       wdog_req = 1'b0;
    logic       cfg_sel = 1'b0;
    logic       wake_pin = 1'b0;
    logic [1:0] pll_cfg_pin = 2'b00;
    logic [1:0] boot_cfg_pin = 2'b00;
    logic       ctl_wr = 1'b0;
    logic [1:0] ctl_wdata = 2'b00;
    logic [1:0] ctl_rd;
    logic       rst_out_n;
    logic       ext_rst_n;
    logic       wake_cfg;
    logic [1:0] pll_cfg;
    logic [1:0] boot_cfg;
    logic [4:0] cause;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [1:0] m_pll  = 2'b00;
    logic [1:0] m_boot = 2'b00;
    logic [4:0] m_cause;

    always #4 clk = ~clk;

    rstseq_top u_rstseq_top (
        .clk(clk), .rst(rst), .pll_locked(pll_locked), .clk_fail(clk_fail),
        .loc_rst_en(loc_rst_en), .ext_rst_req(ext_rst_req), .wdog_req(wdog_req),
        .cfg_sel(cfg_sel), .wake_pin(wake_pin), .pll_cfg_pin(pll_cfg_pin),
        .boot_cfg_pin(boot_cfg_pin), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rd(ctl_rd), .rst_out_n(rst_out_n), .ext_rst_n(ext_rst_n),
        .wake_cfg(wake_cfg), .pll_cfg(pll_cfg), .boot_cfg(boot_cfg), .cause(cause)
    );

    typedef struct packed {
        logic       ext;
        logic       fail;
        logic       en;
        logic       wdog;
        logic       sel;
        logic       wake;
        logic [1:0] pllc;
        logic [1:0] bootc;
        logic [4:0] exp_cause;
        logic       seq;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 2'b01, 5'b00001, 1'b1},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b11, 5'b00010, 1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b01, 2'b10, 5'b00100, 1'b1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 5'b00100, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 2'b11, 5'b00001, 1'b1},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 2'b10, 5'b00010, 1'b1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic e, input logic f, input logic w);
        ext_rst_req = e;
        clk_fail    = f;
        wdog_req    = w;
        @(negedge clk);
        ext_rst_req = 1'b0;
        clk_fail    = 1'b0;
        wdog_req    = 1'b0;
    endtask

    task automatic measure_low(output int n);
        n = 0;
        while (!rst_out_n && n < 500) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int lowcnt;
        bit hi_ok;

        // R1: reset state
        repeat (4) @(negedge clk);
        check(rst_out_n == 1'b0, "R1 rst_out_n in reset", rst_out_n, 0);
        check(ext_rst_n == 1'b0, "R1 ext_rst_n in reset", ext_rst_n, 0);
        check(cause == 5'b0, "R1 cause in reset", cause, 0);
        check(ctl_rd == 2'b0, "R1 ctl_rd in reset", ctl_rd, 0);
        rst = 1'b0;
        @(negedge clk);
        measure_low(n);
        check(cause == 5'b10000, "R1 power-on cause", cause, 16);
        m_cause = cause;

        // Vector table: R2 R3 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            loc_rst_en   = VECS[i].en;
            cfg_sel      = VECS[i].sel;
            wake_pin     = VECS[i].wake;
            pll_cfg_pin  = VECS[i].pllc;
            boot_cfg_pin = VECS[i].bootc;
            @(negedge clk);
            pulse_req(VECS[i].ext, VECS[i].fail, VECS[i].wdog);
            if (VECS[i].seq) begin
                measure_low(n);
                check(n == SEQ_LEN, "R4 sequence length", n, SEQ_LEN);
                if (VECS[i].sel) begin
                    m_pll  = VECS[i].pllc;
                    m_boot = VECS[i].bootc;
                end
                check(wake_cfg == VECS[i].wake, "R3 wake_cfg", wake_cfg, VECS[i].wake);
                check(pll_cfg == m_pll, "R3 pll_cfg", pll_cfg, m_pll);
                check(boot_cfg == m_boot, "R5 boot_cfg", boot_cfg, m_boot);
                check(cause == VECS[i].exp_cause, "R7 R6 cause winner", cause, VECS[i].exp_cause);
            end else begin
                hi_ok = 1;
                repeat (30) begin
                    if (!rst_out_n) hi_ok = 0;
                    @(negedge clk);
                end
                check(hi_ok, "R2 gated loss-of-clock ignored", hi_ok, 1);
                check(cause == VECS[i].exp_cause, "R2 cause unchanged", cause, VECS[i].exp_cause);
            end
            m_cause = cause;
        end
        loc_rst_en = 1'b0;

        // R8: software system reset
        ctl_wr = 1'b1; ctl_wdata = 2'b01;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = 2'b00;
        check(ctl_rd[0] == 1'b1, "R8 bit reads set", ctl_rd[0], 1);
        check(rst_out_n == 1'b1, "R8 not yet in reset", rst_out_n, 1);
        @(negedge clk);
        check(ctl_rd[0] == 1'b0, "R8 bit self-clears", ctl_rd[0], 0);
        measure_low(n);
        check(n == SEQ_LEN, "R8 full sequence length", n, SEQ_LEN);
        check(cause == 5'b01000, "R8 cause software system", cause, 8);
        m_cause = cause;

        // R9: software external reset
        ctl_wr = 1'b1; ctl_wdata = 2'b10;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = 2'b00;
        check(ctl_rd[1] == 1'b1, "R9 bit reads set", ctl_rd[1], 1);
        @(negedge clk);
        check(ctl_rd[1] == 1'b0, "R9 bit self-clears", ctl_rd[1], 0);
        lowcnt = 0;
        hi_ok  = 1;
        repeat (20) begin
            if (!ext_rst_n) lowcnt++;
            if (!rst_out_n) hi_ok = 0;
            @(negedge clk);
        end
        check(lowcnt == PULSE, "R9 external pulse width", lowcnt, PULSE);
        check(hi_ok, "R9 rst_out_n untouched", hi_ok, 1);
        check(cause == m_cause, "R9 cause unchanged", cause, m_cause);

        // R4: waiting for lock
        pll_locked = 1'b0;
        pulse_req(1'b1, 1'b0, 1'b0);
        hi_ok = 1;
        repeat (40) begin
            if (rst_out_n) hi_ok = 0;
            @(negedge clk);
        end
        check(hi_ok, "R4 held while unlocked", hi_ok, 1);
        pll_locked = 1'b1;
        @(negedge clk);
        measure_low(n);
        check(n == POST_LCK, "R4 release after lock", n, POST_LCK);

        // R3 R5: staged sampling
        cfg_sel = 1'b1; wake_pin = 1'b0; boot_cfg_pin = 2'b01; pll_cfg_pin = 2'b10;
        @(negedge clk);
        pulse_req(1'b0, 1'b0, 1'b1);
        check(wake_cfg == 1'b0, "R3 wake applied at entry", wake_cfg, 0);
        check(pll_cfg == 2'b10, "R3 pll applied at entry", pll_cfg, 2);
        repeat (8) @(negedge clk);
        wake_pin = 1'b1;
        repeat (10) @(negedge clk);
        wake_pin = 1'b0;
        boot_cfg_pin = 2'b10;
        measure_low(n);
        check(n == 4, "R5 tail length", n, 4);
        check(wake_cfg == 1'b1, "R5 wake resampled at count end", wake_cfg, 1);
        check(boot_cfg == 2'b01, "R5 boot ignores tail change", boot_cfg, 1);

        // R10: restart
        pulse_req(1'b1, 1'b0, 1'b0);
        repeat (8) @(negedge clk);
        pulse_req(1'b0, 1'b0, 1'b1);
        measure_low(n);
        check(n == SEQ_LEN, "R10 restart length", n, SEQ_LEN);
        check(cause == 5'b00100, "R10 cause of new request", cause, 4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule